// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block is a single-master SMBus host. Software loads a small register file with a target address, a command byte and an optional data byte. It then writes the control register with a protocol code and the go bit. The engine runs one complete transaction on an open-drain clock/data pair. The supported transactions are Send Byte, Receive Byte, Write Byte Data and Read Byte Data. At the end it raises a success flag or an error flag in the status register. Software clears these flags by writing ones to them.

The bus lines are driven only low. The outputs `scl_lo` and `sda_lo` request a low level, and the real wired levels come back on `scl_i` and `sda_i`. A programmable divider sets the bit rate: every bit takes four divider ticks. A programmable timeout catches a clock line that a target holds low for too long. A single level output requests service while any result flag is set.

Top module: `smb_host`

## Requirements
- R1: After reset, every register reads zero, both line-drive outputs are low (lines released), and `irq` is low. Register offsets are: 0 status, 1 control, 2 command, 3 address, 4 data. Any other offset reads zero.
- R2: Status bit 0 (busy) reads 1 from the edge that accepts a go request until the transaction ends. It ignores writes. A go request made while busy is ignored, so no extra bytes go onto the bus and no flag is raised.
- R3: Control code 001 with address bit 0 = 0 (Send Byte) puts the address byte {addr[7:1],0} and then the command byte on the bus. After the stop condition, status reads 0x02 (bit 1 = success).
- R4: Control bit 6 is the go bit and always reads back 0. Control bits 7, 5 and [4:2] read back as last written.
- R5: Control code 010 with address bit 0 = 0 (Write Byte Data) puts the address byte, the command byte and the data byte on the bus, then stops with status 0x02.
- R6: Status bits [4:1] are sticky. Writing 1 to a set bit clears it. Writing 1 to a clear bit, or writing 0, changes nothing.
- R7: Control code 001 with address bit 0 = 1 (Receive Byte) sends {addr[7:1],1}, reads one byte, and stores it in the command register.
- R8: Control code 010 with address bit 0 = 1 (Read Byte Data) sends {addr[7:1],0} and the command byte, then a repeated start and {addr[7:1],1}. It stores the returned byte in the data register and leaves the command register unchanged.
- R9: A NACK on the address or on any written byte sets status bit 2 (status 0x04). The engine then drives a stop condition and releases both lines.
- R10: If the clock line stays low for `cfg_tmo` cycles while the engine waits for it to rise, status bit 3 is set (status 0x08). The engine then releases both lines and goes idle without driving a stop.
- R11: A go request with a control code other than 001 or 010 sets status bit 4 (status 0x10) at once and causes no bus activity.
- R12: The clock period on the bus is 4*(`cfg_div`+1) core cycles.
- R13: `irq` is high exactly while any of status bits [4:1] is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| cfg_div | input | DIV_W | Bit-rate divider: one tick every `cfg_div`+1 cycles |
| cfg_tmo | input | TMO_W | Clock-low timeout limit in core cycles |
| scl_i | input | 1 | Wired level of the clock line |
| sda_i | input | 1 | Wired level of the data line |
| scl_lo | output | 1 | 1 pulls the clock line low |
| sda_lo | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Level service request |

## Verification
A target model on the wired bus records every byte it receives, and each byte is scored against the sequence the driver expects for that protocol. A wrong step in the transaction sequencer therefore shows up as a wrong or missing byte within one byte time, about 36 ticks. A misplaced phase or a bad ACK sample shows up as the wrong status code or a wrong value in the destination register once the engine drops busy. Errors in the flag logic show up at the status read and on `irq` in the first cycle after the result event.

// File: rtl/smb_pkg.sv
// Shared types for the SMBus host: register offsets, protocol codes and
// the per-step operation decoder that orders each transaction.
package smb_pkg;

    localparam logic [2:0] RA_STATUS = 3'd0;
    localparam logic [2:0] RA_CTRL   = 3'd1;
    localparam logic [2:0] RA_CMD    = 3'd2;
    localparam logic [2:0] RA_ADDR   = 3'd3;
    localparam logic [2:0] RA_DATA   = 3'd4;

    localparam logic [2:0] PROTO_BYTE  = 3'b001;
    localparam logic [2:0] PROTO_BDATA = 3'b010;

    typedef enum logic [1:0] {OP_START, OP_TX, OP_RX, OP_STOP} op_kind_e;
    typedef enum logic [1:0] {SRC_AW, SRC_AR, SRC_CMD, SRC_DAT} op_src_e;

    typedef struct packed {
        op_kind_e kind;
        op_src_e  src;
    } op_t;

    function automatic op_t mk_op(input op_kind_e k, input op_src_e s);
        op_t o;
        o.kind = k;
        o.src  = s;
        return o;
    endfunction

    // Returns the operation for a step of the selected transaction.
    function automatic op_t seq_op(input logic wide, input logic rd, input logic [2:0] step);
        op_t o;
        o = mk_op(OP_STOP, SRC_CMD);
        if (!wide) begin
            case (step)
                3'd0: o = mk_op(OP_START, SRC_AW);
                3'd1: o = mk_op(OP_TX, rd ? SRC_AR : SRC_AW);
                3'd2: o = rd ? mk_op(OP_RX, SRC_CMD) : mk_op(OP_TX, SRC_CMD);
                default: o = mk_op(OP_STOP, SRC_CMD);
            endcase
        end else if (!rd) begin
            case (step)
                3'd0: o = mk_op(OP_START, SRC_AW);
                3'd1: o = mk_op(OP_TX, SRC_AW);
                3'd2: o = mk_op(OP_TX, SRC_CMD);
                3'd3: o = mk_op(OP_TX, SRC_DAT);
                default: o = mk_op(OP_STOP, SRC_CMD);
            endcase
        end else begin
            case (step)
                3'd0: o = mk_op(OP_START, SRC_AW);
                3'd1: o = mk_op(OP_TX, SRC_AW);
                3'd2: o = mk_op(OP_TX, SRC_CMD);
                3'd3: o = mk_op(OP_START, SRC_AR);
                3'd4: o = mk_op(OP_TX, SRC_AR);
                3'd5: o = mk_op(OP_RX, SRC_DAT);
                default: o = mk_op(OP_STOP, SRC_CMD);
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/smb_tick.sv
// Bit-rate divider. Emits one tick every cfg_div+1 cycles while run is high.
// Assumes cfg_div is held stable while run is high; the count restarts at
// zero whenever run is low so transaction timing is repeatable.
module smb_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == cfg_div);

    // Count the cycles between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/smb_tmo.sv
// Clock-low watchdog. Counts cycles while the engine has released the clock
// and waits for it to rise but the wired clock stays low. Raises hit when the
// count reaches cfg_tmo. Assumes the engine leaves the wait state on hit.
module smb_tmo #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             scl_i,
    input  logic [TMO_W-1:0] cfg_tmo,
    output logic             hit
);
    logic [TMO_W-1:0] cnt;
    logic             held;

    assign held = waiting && !scl_i;
    assign hit  = held && (cnt == cfg_tmo);

    // Measure how long the clock has been held low.
    always_ff @(posedge clk) begin
        if (!rst_n || !held) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/smb_regs.sv
// Register file: status (sticky flags plus live busy), control with the
// self-clearing go bit, command, address and data. Decodes go requests and
// takes received bytes from the engine. Assumes one register access per cycle.
module smb_regs
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy,
    input  logic       ev_ok,
    input  logic       ev_nack,
    input  logic       ev_tmo,
    input  logic       rx_we,
    input  logic       rx_to_cmd,
    input  logic [7:0] rx_byte,
    output logic       go,
    output logic       wide,
    output logic       dir_rd,
    output logic [6:0] addr7,
    output logic [7:0] cmd_q,
    output logic [7:0] dat_q,
    output logic [4:1] flags
);
    logic [7:0] ctrl_q;
    logic [7:0] addr_q;
    logic       wr_stat, wr_ctrl, start_req, proto_ok, bad;
    logic [4:1] w1c, set;

    assign wr_stat   = reg_we && (reg_addr == RA_STATUS);
    assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
    assign start_req = wr_ctrl && reg_wdata[6] && !busy;
    assign proto_ok  = (reg_wdata[4:2] == PROTO_BYTE) || (reg_wdata[4:2] == PROTO_BDATA);
    assign go        = start_req && proto_ok;
    assign bad       = start_req && !proto_ok;
    assign wide      = (reg_wdata[4:2] == PROTO_BDATA);
    assign dir_rd    = addr_q[0];
    assign addr7     = addr_q[7:1];
    assign w1c       = wr_stat ? reg_wdata[4:1] : 4'b0;
    assign set       = {bad, ev_tmo, ev_nack, ev_ok};

    // Hold the registers; engine results take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= '0;
            ctrl_q <= '0;
            cmd_q  <= '0;
            addr_q <= '0;
            dat_q  <= '0;
        end else begin
            flags <= (flags & ~w1c) | set;
            if (wr_ctrl) ctrl_q <= {reg_wdata[7], 1'b0, reg_wdata[5:0]};
            if (rx_we && rx_to_cmd)                   cmd_q <= rx_byte;
            else if (reg_we && reg_addr == RA_CMD)    cmd_q <= reg_wdata;
            if (reg_we && reg_addr == RA_ADDR)        addr_q <= reg_wdata;
            if (rx_we && !rx_to_cmd)                  dat_q <= rx_byte;
            else if (reg_we && reg_addr == RA_DATA)   dat_q <= reg_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = {3'b000, flags, busy};
            RA_CTRL:   reg_rdata = ctrl_q;
            RA_CMD:    reg_rdata = cmd_q;
            RA_ADDR:   reg_rdata = addr_q;
            RA_DATA:   reg_rdata = dat_q;
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/smb_engine.sv
// Transaction and bit sequencer. Each operation (start, byte out, byte in,
// stop) spans four divider ticks per bit: set data, release clock, wait for
// the clock high and act, pull the clock low. A NACK diverts to the stop.
// Assumes the address, command and data registers are stable while busy.
module smb_engine
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       wide,
    input  logic       dir_rd,
    input  logic [6:0] addr7,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] dat_byte,
    input  logic       tick,
    input  logic       tmo_hit,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       busy,
    output logic       waiting,
    output logic       scl_lo,
    output logic       sda_lo,
    output logic       ev_ok,
    output logic       ev_nack,
    output logic       ev_tmo,
    output logic       rx_we,
    output logic       rx_to_cmd,
    output logic [7:0] rx_byte
);
    logic [2:0] step;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic       wide_q, rd_q, nack_q, ack_hi;
    op_t        cur;
    logic [7:0] tx_byte;
    logic       drive0, is_bit;

    assign cur     = nack_q ? mk_op(OP_STOP, SRC_CMD) : seq_op(wide_q, rd_q, step);
    assign is_bit  = (cur.kind == OP_TX) || (cur.kind == OP_RX);
    assign waiting = busy && (ph == 2'd2);

    // Select the byte that the current output operation shifts out.
    always_comb begin
        case (cur.src)
            SRC_AW:  tx_byte = {addr7, 1'b0};
            SRC_AR:  tx_byte = {addr7, 1'b1};
            SRC_CMD: tx_byte = cmd_byte;
            default: tx_byte = dat_byte;
        endcase
    end

    // Data-line level to set while the clock is low.
    always_comb begin
        case (cur.kind)
            OP_START: drive0 = 1'b0;
            OP_STOP:  drive0 = 1'b1;
            OP_TX:    drive0 = (bitn < 4'd8) ? ~tx_byte[3'(4'd7 - bitn)] : 1'b0;
            default:  drive0 = 1'b0;
        endcase
    end

    // Advance phases, bits and steps; report results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; step <= '0; ph <= '0; bitn <= '0;
            wide_q <= 1'b0; rd_q <= 1'b0; nack_q <= 1'b0; ack_hi <= 1'b0;
            scl_lo <= 1'b0; sda_lo <= 1'b0;
            ev_ok <= 1'b0; ev_nack <= 1'b0; ev_tmo <= 1'b0;
            rx_we <= 1'b0; rx_to_cmd <= 1'b0; rx_byte <= '0;
        end else begin
            ev_ok <= 1'b0; ev_nack <= 1'b0; ev_tmo <= 1'b0; rx_we <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1; step <= '0; ph <= '0; bitn <= '0;
                    nack_q <= 1'b0; wide_q <= wide; rd_q <= dir_rd;
                end
            end else if (tmo_hit) begin
                busy <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0; ev_tmo <= 1'b1;
            end else if (tick && (ph != 2'd2 || scl_i)) begin
                ph <= ph + 2'd1;
                case (ph)
                    2'd0: sda_lo <= drive0;
                    2'd1: scl_lo <= 1'b0;
                    2'd2: begin
                        if (cur.kind == OP_START)     sda_lo <= 1'b1;
                        else if (cur.kind == OP_STOP) sda_lo <= 1'b0;
                        else if (bitn < 4'd8)         rx_byte <= {rx_byte[6:0], sda_i};
                        else                          ack_hi <= sda_i;
                    end
                    default: begin
                        if (cur.kind == OP_STOP) begin
                            busy <= 1'b0; ev_ok <= !nack_q; ev_nack <= nack_q;
                        end else begin
                            scl_lo <= 1'b1;
                            if (is_bit && bitn != 4'd8) begin
                                bitn <= bitn + 4'd1;
                            end else begin
                                bitn <= '0;
                                step <= step + 3'd1;
                                if (cur.kind == OP_TX && ack_hi) nack_q <= 1'b1;
                                if (cur.kind == OP_RX) begin
                                    rx_we <= 1'b1;
                                    rx_to_cmd <= (cur.src == SRC_CMD);
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_host.sv
// SMBus host top: register file, bit-rate divider, clock-low watchdog and
// transaction sequencer. Assumes external pull-ups on both lines and that
// cfg_div and cfg_tmo change only while the engine is idle.
module smb_host #(
    parameter int DIV_W = 12,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_lo,
    output logic             sda_lo,
    output logic             irq
);
    logic       busy, waiting, tick, tmo_hit, go, wide, dir_rd;
    logic       ev_ok, ev_nack, ev_tmo, rx_we, rx_to_cmd;
    logic [7:0] rx_byte, cmd_q, dat_q;
    logic [6:0] addr7;
    logic [4:1] flags;

    assign irq = |flags;

    smb_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .ev_ok(ev_ok), .ev_nack(ev_nack), .ev_tmo(ev_tmo), .rx_we(rx_we),
        .rx_to_cmd(rx_to_cmd), .rx_byte(rx_byte), .go(go), .wide(wide),
        .dir_rd(dir_rd), .addr7(addr7), .cmd_q(cmd_q), .dat_q(dat_q),
        .flags(flags)
    );

    smb_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .cfg_div(cfg_div), .tick(tick)
    );

    smb_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .scl_i(scl_i),
        .cfg_tmo(cfg_tmo), .hit(tmo_hit)
    );

    smb_engine u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .wide(wide), .dir_rd(dir_rd),
        .addr7(addr7), .cmd_byte(cmd_q), .dat_byte(dat_q), .tick(tick),
        .tmo_hit(tmo_hit), .scl_i(scl_i), .sda_i(sda_i), .busy(busy),
        .waiting(waiting), .scl_lo(scl_lo), .sda_lo(sda_lo), .ev_ok(ev_ok),
        .ev_nack(ev_nack), .ev_tmo(ev_tmo), .rx_we(rx_we),
        .rx_to_cmd(rx_to_cmd), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/smb_host_chk.sv
// Protocol checker for smb_host, attached by bind. It observes the bus
// drives, busy, the result flags and the register port.
module smb_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       scl_lo,
    input logic       sda_lo,
    input logic [4:1] flags,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_rdata
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_lo && !sda_lo)); // R1

    AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(reg_we && reg_addr == 3'd0)); // R6

    AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd1) |-> !reg_rdata[6]); // R4

    AST_END_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> (|flags[3:1])); // R2

    AST_BAD_CODE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> !busy); // R11

    AST_OK_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> (!scl_lo && !sda_lo)); // R3
endmodule

bind smb_host smb_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .scl_lo(scl_lo), .sda_lo(sda_lo),
    .flags(flags), .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/smb_host_test.sv
// Scoreboard bench: driver tasks push the bus bytes each transaction must
// produce; a target model on the wired bus pops and compares each byte.
module smb_host_test;
    localparam int DIV_W = 12;
    localparam int TMO_W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic             reg_we = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [DIV_W-1:0] cfg_div = 12'd1;
    logic [TMO_W-1:0] cfg_tmo = 16'd300;
    logic             scl_lo, sda_lo, irq;
    logic             sl_sda_lo = 1'b0;
    logic             sl_scl_hold = 1'b0;
    wire              scl_bus = !scl_lo && !sl_scl_hold;
    wire              sda_bus = !sda_lo && !sl_sda_lo;

    smb_host #(.DIV_W(DIV_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_div(cfg_div),
        .cfg_tmo(cfg_tmo), .scl_i(scl_bus), .sda_i(sda_bus), .scl_lo(scl_lo),
        .sda_lo(sda_lo), .irq(irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done_run = 1'b0;
    string cur_req = "R3";
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- target model and byte monitor ----------------
    logic [6:0] slv_addr = 7'h50;
    logic [7:0] rd_byte = 8'h00;
    bit         nack_data = 1'b0;
    bit         active = 1'b0, skip_fall = 1'b0, in_addr = 1'b0;
    bit         reading = 1'b0, reading_next = 1'b0;
    int         bitcnt = 0, cyc = 0, rise0 = 0, period = 0;
    logic [7:0] sh = '0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
            active = 1'b1; skip_fall = 1'b1; in_addr = 1'b1; bitcnt = 0;
            reading = 1'b0; reading_next = 1'b0; sl_sda_lo = 1'b0;
        end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
            active = 1'b0; sl_sda_lo = 1'b0;
        end else if (active && scl_bus && !prev_scl) begin
            if (bitcnt == 0) rise0 = cyc;
            if (bitcnt == 1) period = cyc - rise0;
            if (!reading && bitcnt < 8) sh = {sh[6:0], sda_bus};
        end else if (active && !scl_bus && prev_scl) begin
            if (skip_fall) begin
                skip_fall = 1'b0;
            end else begin
                bitcnt++;
                if (bitcnt == 8 && !reading) begin
                    if (exp_q.size() == 0) chk(1'b0, cur_req, sh, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(sh == e, cur_req, sh, e);
                    end
                    if (in_addr) begin
                        sl_sda_lo = (sh[7:1] == slv_addr);
                        reading_next = sh[0] && (sh[7:1] == slv_addr);
                    end else begin
                        sl_sda_lo = !nack_data;
                    end
                end else if (bitcnt == 9) begin
                    bitcnt = 0; in_addr = 1'b0; sl_sda_lo = 1'b0;
                    reading = reading_next; reading_next = 1'b0;
                    if (reading) sl_sda_lo = ~rd_byte[7];
                end else if (reading && bitcnt < 8) begin
                    sl_sda_lo = ~rd_byte[7 - bitcnt];
                end else if (reading) begin
                    sl_sda_lo = 1'b0;
                end
            end
        end
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd0, s);
            if (!s[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        exp_q.push_back(b);
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == e, req, v, e);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) expect_reg(3'(a), 8'h00, "R1");
        chk(!scl_lo && !sda_lo, "R1", {scl_lo, sda_lo}, 0);
        chk(!irq, "R1", irq, 0);

        // R3: Send Byte
        cur_req = "R3";
        wr(3'd3, 8'hA0); wr(3'd2, 8'hA5);
        push(8'hA0); push(8'hA5);
        wr(3'd1, 8'h44);
        expect_reg(3'd0, 8'h01, "R2");
        expect_reg(3'd1, 8'h04, "R4");
        wait_idle();
        expect_reg(3'd0, 8'h02, "R3");
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        chk(irq == 1'b1, "R13", irq, 1);
        chk(period == 8, "R12", period, 8);

        // R6 and R2: write-one-to-clear, busy ignores writes
        wr(3'd0, 8'h05);
        expect_reg(3'd0, 8'h02, "R6");
        wr(3'd0, 8'h02);
        expect_reg(3'd0, 8'h00, "R6");
        chk(irq == 1'b0, "R13", irq, 0);

        // R5: Write Byte Data
        cur_req = "R5";
        wr(3'd2, 8'h33); wr(3'd4, 8'h5A);
        push(8'hA0); push(8'h33); push(8'h5A);
        wr(3'd1, 8'h48);
        wait_idle();
        expect_reg(3'd0, 8'h02, "R5");
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        wr(3'd0, 8'h1E);

        // R7: Receive Byte lands in the command register
        cur_req = "R7";
        rd_byte = 8'h3C;
        wr(3'd3, 8'hA1);
        push(8'hA1);
        wr(3'd1, 8'h44);
        wait_idle();
        expect_reg(3'd0, 8'h02, "R7");
        expect_reg(3'd2, 8'h3C, "R7");
        wr(3'd0, 8'h1E);

        // R8: Read Byte Data with repeated start
        cur_req = "R8";
        rd_byte = 8'hC3;
        wr(3'd2, 8'h12);
        push(8'hA0); push(8'h12); push(8'hA1);
        wr(3'd1, 8'h48);
        wait_idle();
        expect_reg(3'd0, 8'h02, "R8");
        expect_reg(3'd4, 8'hC3, "R8");
        expect_reg(3'd2, 8'h12, "R8");
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
        wr(3'd0, 8'h1E);

        // R9: NACK on address
        cur_req = "R9";
        wr(3'd3, 8'h66);
        push(8'h66);
        wr(3'd1, 8'h44);
        wait_idle();
        expect_reg(3'd0, 8'h04, "R9");
        chk(scl_bus && sda_bus && !active, "R9", {scl_bus, sda_bus, active}, 3'b110);
        chk(irq == 1'b1, "R13", irq, 1);
        wr(3'd0, 8'h1E);

        // R9: NACK on a written byte
        nack_data = 1'b1;
        wr(3'd3, 8'hA0); wr(3'd2, 8'h77); wr(3'd4, 8'h88);
        push(8'hA0); push(8'h77);
        wr(3'd1, 8'h48);
        wait_idle();
        expect_reg(3'd0, 8'h04, "R9");
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
        nack_data = 1'b0;
        wr(3'd0, 8'h1E);

        // R10: clock held low until timeout
        cur_req = "R10";
        sl_scl_hold = 1'b1;
        wr(3'd1, 8'h44);
        wait_idle();
        expect_reg(3'd0, 8'h08, "R10");
        chk(!scl_lo && !sda_lo, "R10", {scl_lo, sda_lo}, 0);
        sl_scl_hold = 1'b0;
        wr(3'd0, 8'h1E);

        // R11: unsupported protocol code
        cur_req = "R11";
        wr(3'd1, 8'h4C);
        expect_reg(3'd0, 8'h10, "R11");
        chk(!scl_lo && !sda_lo, "R11", {scl_lo, sda_lo}, 0);
        expect_reg(3'd1, 8'h0C, "R4");
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && !active, "R11", active, 0);
        wr(3'd0, 8'h1E);

        // R2: go while busy is ignored
        cur_req = "R2";
        wr(3'd2, 8'h99);
        push(8'hA0); push(8'h99);
        wr(3'd1, 8'h44);
        wr(3'd1, 8'h48);
        wait_idle();
        expect_reg(3'd0, 8'h02, "R2");
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        wr(3'd0, 8'h1E);

        // R12: slower divider
        cur_req = "R12";
        cfg_div = 12'd3;
        push(8'hA0); push(8'h99);
        wr(3'd1, 8'h44);
        wait_idle();
        chk(period == 16, "R12", period, 16);
        expect_reg(3'd0, 8'h02, "R12");
        wr(3'd0, 8'h1E);

        done_run = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(negedge clk);
        if (!done_run) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule